// File: doc/BRIEF.md
# Narrow-Bus Address and Read-Data Serializer

This block links a 32-bit transaction source to a 16-bit application port. When a request is accepted it sends the transaction address out in 16-bit pieces, low half first. Each piece carries two sideband flags: a burst flag and a dual-address flag. The address phase is one piece long when the decoded window is 16 bits or narrower, and two pieces long when the window is wider. An active-low strobe marks the last address piece.

After the address phase the block collects read data from the application. The data arrives as 16-bit pieces, each qualified by an active-low enable. Each pair of pieces is rebuilt into a 32-bit word, and the word is shown for one cycle. An active-low data-last strobe on the final piece closes the phase and returns the block to idle.

A data-last strobe without the enable is reported as a protocol error. So is a data-last strobe on the low piece of a word.

Top module: `narrow_port_serdes`

## Requirements
- R1: After a synchronous active-high reset: `ready`=1, `nb_word`=0, `nb_addr_last_n`=1, `rd_word_valid`=0 and `proto_err`=0.
- R2: A request is taken only when `req_valid`=1 and `ready`=1 at a clock edge. A `req_valid` seen while busy is ignored, so no extra address phase follows the current transaction.
- R3: In the cycle after acceptance, `nb_word` = {burst, dual, addr[15:0]}. Bit 17 holds the burst flag and bit 16 holds the dual-address flag.
- R4: When `req_bar_bits` > 16 the address phase takes two cycles. The second piece is {burst, dual, addr[31:16]}. `nb_addr_last_n` is 1 on the first piece and 0 on the second.
- R5: When `req_bar_bits` <= 16 the address phase is one cycle, with `nb_addr_last_n`=0 on it. After the final address piece there is one cycle with `nb_word`=0 and `nb_addr_last_n`=1, and then the data phase starts.
- R6: In the data phase, enabled pieces (`rd_en_n`=0) alternate low half, then high half. In the cycle after the high piece, `rd_word_valid`=1 for exactly one cycle and `rd_word`={high, low}.
- R7: A piece with `rd_en_n`=1 is ignored. It produces no word and does not advance the low/high pairing.
- R8: An enabled high piece with `rd_data_last_n`=0 ends the phase, and `ready`=1 in the following cycle.
- R9: `rd_data_last_n`=0 together with `rd_en_n`=1 raises `proto_err` for one cycle in the next cycle, and does not end the phase.
- R10: An enabled low piece with `rd_data_last_n`=0 raises `proto_err` for one cycle. It ends the phase without a word.
- R11: `ready` is 0 from the cycle after acceptance until the phase ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Transaction address |
| req_burst | input | 1 | Burst flag |
| req_dual | input | 1 | Dual-address flag |
| req_bar_bits | input | 6 | Decoded address window size in bits |
| ready | output | 1 | Idle and able to accept a request |
| nb_word | output | 18 | Narrow-bus word: flags in bits 17..16, address piece in bits 15..0 |
| nb_addr_last_n | output | 1 | Active-low last address piece |
| rd_piece | input | 16 | Read-data piece |
| rd_en_n | input | 1 | Active-low read-data enable |
| rd_data_last_n | input | 1 | Active-low last data piece |
| rd_word | output | 32 | Rebuilt read-data word |
| rd_word_valid | output | 1 | One-cycle pulse marking `rd_word` |
| proto_err | output | 1 | One-cycle protocol error pulse |

## Verification
The bench sweeps window sizes on both sides of the 16-bit threshold. A design that compared with the wrong bound, or put the last strobe on the low piece, would show a missing or misplaced address strobe. Pieces with the enable deasserted are mixed between real pieces. A joiner that counted them would swap the word halves or emit words too early. Requests held high while the block is busy must not start a second address phase. A data-last strobe on a low piece, or without the enable, must raise the error pulse. A design that got this wrong would stay stuck in the data phase, or close it on the wrong piece.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ALO  = 2'd1,
        ST_AHI  = 2'd2,
        ST_DATA = 2'd3
    } nbs_state_e;
endpackage

// File: rtl/nbs_addr_seq.sv
module nbs_addr_seq
    import nbs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int HALF_W = 16,
    parameter int BW     = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_burst,
    input  logic                req_dual,
    input  logic [BW-1:0]       req_bar_bits,
    input  logic                phase_done,
    output logic                ready,
    output logic                data_phase,
    output logic [HALF_W+1:0]   word_out,
    output logic                last_n
);
    localparam logic [BW-1:0] HALF_LIM = BW'(HALF_W);

    typedef struct packed {
        nbs_state_e          st;
        logic [ADDR_W-1:0]   addr;
        logic                burst;
        logic                dual;
        logic                wide;
        logic [HALF_W+1:0]   word;
        logic                last_n;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.word   = '0;
        s_d.last_n = 1'b1;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.st     = ST_ALO;
                    s_d.addr   = req_addr;
                    s_d.burst  = req_burst;
                    s_d.dual   = req_dual;
                    s_d.wide   = (req_bar_bits > HALF_LIM);
                    s_d.word   = {req_burst, req_dual, req_addr[HALF_W-1:0]};
                    s_d.last_n = (req_bar_bits > HALF_LIM);
                end
            end
            ST_ALO: begin
                if (s_q.wide) begin
                    s_d.st     = ST_AHI;
                    s_d.word   = {s_q.burst, s_q.dual, s_q.addr[ADDR_W-1:HALF_W]};
                    s_d.last_n = 1'b0;
                end else begin
                    s_d.st = ST_DATA;
                end
            end
            ST_AHI: s_d.st = ST_DATA;
            ST_DATA: begin
                if (phase_done) s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q        <= '0;
            s_q.st     <= ST_IDLE;
            s_q.last_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready      = (s_q.st == ST_IDLE);
    assign data_phase = (s_q.st == ST_DATA);
    assign word_out   = s_q.word;
    assign last_n     = s_q.last_n;
endmodule

// File: rtl/nbs_data_join.sv
module nbs_data_join #(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                data_phase,
    input  logic [HALF_W-1:0]   rd_piece,
    input  logic                rd_en_n,
    input  logic                rd_data_last_n,
    output logic                phase_done,
    output logic [2*HALF_W-1:0] word,
    output logic                word_valid,
    output logic                err
);
    typedef struct packed {
        logic                hi_next;
        logic [HALF_W-1:0]   lo;
        logic [2*HALF_W-1:0] word;
        logic                valid;
        logic                err;
    } join_t;

    join_t j_d, j_q;
    logic  done_c;

    always_comb begin
        j_d       = j_q;
        j_d.valid = 1'b0;
        j_d.err   = !rd_data_last_n && rd_en_n;
        done_c    = 1'b0;
        if (!data_phase) begin
            j_d.hi_next = 1'b0;
        end else if (!rd_en_n) begin
            if (!j_q.hi_next) begin
                j_d.lo      = rd_piece;
                j_d.hi_next = 1'b1;
                if (!rd_data_last_n) begin
                    j_d.err     = 1'b1;
                    j_d.hi_next = 1'b0;
                    done_c      = 1'b1;
                end
            end else begin
                j_d.word    = {rd_piece, j_q.lo};
                j_d.valid   = 1'b1;
                j_d.hi_next = 1'b0;
                done_c      = !rd_data_last_n;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) j_q <= '0;
        else     j_q <= j_d;
    end

    assign phase_done = done_c;
    assign word       = j_q.word;
    assign word_valid = j_q.valid;
    assign err        = j_q.err;
endmodule

// File: rtl/narrow_port_serdes.sv
module narrow_port_serdes #(
    parameter int ADDR_W = 32,
    parameter int HALF_W = 16,
    parameter int BW     = $clog2(ADDR_W) + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_burst,
    input  logic                req_dual,
    input  logic [BW-1:0]       req_bar_bits,
    output logic                ready,
    output logic [HALF_W+1:0]   nb_word,
    output logic                nb_addr_last_n,
    input  logic [HALF_W-1:0]   rd_piece,
    input  logic                rd_en_n,
    input  logic                rd_data_last_n,
    output logic [2*HALF_W-1:0] rd_word,
    output logic                rd_word_valid,
    output logic                proto_err
);
    logic data_phase;
    logic phase_done;

    nbs_addr_seq #(.ADDR_W(ADDR_W), .HALF_W(HALF_W), .BW(BW)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_burst    (req_burst),
        .req_dual     (req_dual),
        .req_bar_bits (req_bar_bits),
        .phase_done   (phase_done),
        .ready        (ready),
        .data_phase   (data_phase),
        .word_out     (nb_word),
        .last_n       (nb_addr_last_n)
    );

    nbs_data_join #(.HALF_W(HALF_W)) u_join (
        .clk            (clk),
        .rst            (rst),
        .data_phase     (data_phase),
        .rd_piece       (rd_piece),
        .rd_en_n        (rd_en_n),
        .rd_data_last_n (rd_data_last_n),
        .phase_done     (phase_done),
        .word           (rd_word),
        .word_valid     (rd_word_valid),
        .err            (proto_err)
    );
endmodule

// File: rtl/narrow_port_serdes_chk.sv
module narrow_port_serdes_chk #(
    parameter int ADDR_W = 32,
    parameter int HALF_W = 16,
    parameter int BW     = 6
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic [ADDR_W-1:0]   req_addr,
    input logic                ready,
    input logic [HALF_W+1:0]   nb_word,
    input logic                nb_addr_last_n,
    input logic                rd_en_n,
    input logic                rd_data_last_n,
    input logic                rd_word_valid,
    input logic                proto_err
);
    assert_take_lo_half_R3: assert property (@(posedge clk) disable iff (rst)
        (ready && req_valid) |=> (nb_word[HALF_W-1:0] == $past(req_addr[HALF_W-1:0])));

    assert_busy_after_take_R11: assert property (@(posedge clk) disable iff (rst)
        (ready && req_valid) |=> !ready);

    assert_single_last_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        !nb_addr_last_n |=> nb_addr_last_n);

    assert_word_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        rd_word_valid |=> !rd_word_valid);

    assert_word_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
        rd_word_valid |-> !$past(rd_en_n));

    assert_stray_last_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (!rd_data_last_n && rd_en_n) |=> proto_err);
endmodule

bind narrow_port_serdes narrow_port_serdes_chk #(
    .ADDR_W(ADDR_W), .HALF_W(HALF_W), .BW(BW)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_addr       (req_addr),
    .ready          (ready),
    .nb_word        (nb_word),
    .nb_addr_last_n (nb_addr_last_n),
    .rd_en_n        (rd_en_n),
    .rd_data_last_n (rd_data_last_n),
    .rd_word_valid  (rd_word_valid),
    .proto_err      (proto_err)
);

// File: tb/tb_narrow_port_serdes.sv
module tb_narrow_port_serdes;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_burst = 1'b0;
    logic        req_dual = 1'b0;
    logic [5:0]  req_bar_bits = '0;
    logic        ready;
    logic [17:0] nb_word;
    logic        nb_addr_last_n;
    logic [15:0] rd_piece = '0;
    logic        rd_en_n = 1'b1;
    logic        rd_data_last_n = 1'b1;
    logic [31:0] rd_word;
    logic        rd_word_valid;
    logic        proto_err;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    narrow_port_serdes dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_burst(req_burst), .req_dual(req_dual), .req_bar_bits(req_bar_bits),
        .ready(ready), .nb_word(nb_word), .nb_addr_last_n(nb_addr_last_n),
        .rd_piece(rd_piece), .rd_en_n(rd_en_n), .rd_data_last_n(rd_data_last_n),
        .rd_word(rd_word), .rd_word_valid(rd_word_valid), .proto_err(proto_err)
    );

    function automatic logic [17:0] exp_piece(logic b, logic d, logic [31:0] a, bit hi);
        return {b, d, (hi ? a[31:16] : a[15:0])};
    endfunction

    function automatic bit is_wide(logic [5:0] bits);
        return bits > 6'd16;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #5;
    endtask

    task automatic run_txn(input logic [31:0] a, input logic b, input logic d,
                           input logic [5:0] bits, input int nwords, input bit noise);
        req_addr = a; req_burst = b; req_dual = d; req_bar_bits = bits; req_valid = 1'b1;
        tick;
        req_valid = noise;
        req_addr  = $urandom;
        req_burst = $urandom; req_dual = $urandom;
        check("R3 low address piece", 32'(nb_word), 32'(exp_piece(b, d, a, 1'b0)));
        check("R11 busy after accept", 32'(ready), 32'd0);
        if (is_wide(bits)) begin
            check("R4 first piece not last", 32'(nb_addr_last_n), 32'd1);
            tick;
            check("R4 high address piece", 32'(nb_word), 32'(exp_piece(b, d, a, 1'b1)));
            check("R4 last strobe on high piece", 32'(nb_addr_last_n), 32'd0);
        end else begin
            check("R5 single piece is last", 32'(nb_addr_last_n), 32'd0);
        end
        tick;
        check("R5 gap cycle word", 32'(nb_word), 32'd0);
        check("R5 gap cycle strobe", 32'(nb_addr_last_n), 32'd1);
        for (int w = 0; w < nwords; w++) begin
            logic [31:0] dw;
            dw = $urandom;
            if ($urandom_range(0, 2) == 0) begin
                rd_en_n = 1'b1; rd_piece = $urandom; rd_data_last_n = 1'b1;
                tick;
                check("R7 disabled piece gives no word", 32'(rd_word_valid), 32'd0);
            end
            rd_en_n = 1'b0; rd_piece = dw[15:0]; rd_data_last_n = 1'b1;
            tick;
            check("R6 no word after low piece", 32'(rd_word_valid), 32'd0);
            if ($urandom_range(0, 2) == 0) begin
                rd_en_n = 1'b1; rd_piece = $urandom;
                tick;
                check("R7 disabled piece between halves", 32'(rd_word_valid), 32'd0);
            end
            rd_en_n = 1'b0; rd_piece = dw[31:16];
            rd_data_last_n = (w == nwords - 1) ? 1'b0 : 1'b1;
            tick;
            rd_en_n = 1'b1; rd_data_last_n = 1'b1;
            check("R6 word valid", 32'(rd_word_valid), 32'd1);
            check("R6 word value", rd_word, dw);
            if (w == nwords - 1) begin
                req_valid = 1'b0;
                check("R8 ready after last piece", 32'(ready), 32'd1);
            end else begin
                check("R11 busy inside phase", 32'(ready), 32'd0);
            end
        end
        tick;
        check("R6 word pulse one cycle", 32'(rd_word_valid), 32'd0);
        check("R2 no extra address phase", 32'(nb_word), 32'd0);
        check("R2 still ready", 32'(ready), 32'd1);
    endtask

    initial begin
        void'($urandom(32'h1357_2468));
        repeat (3) @(posedge clk);
        #5;
        check("R1 ready", 32'(ready), 32'd1);
        check("R1 word", 32'(nb_word), 32'd0);
        check("R1 addr last", 32'(nb_addr_last_n), 32'd1);
        check("R1 word valid", 32'(rd_word_valid), 32'd0);
        check("R1 error", 32'(proto_err), 32'd0);
        rst = 1'b0;
        tick;

        run_txn(32'hDEAD_BEEF, 1'b1, 1'b0, 6'd16, 1, 1'b0);
        run_txn(32'h1234_5678, 1'b0, 1'b1, 6'd17, 2, 1'b1);
        run_txn(32'hFFFF_0001, 1'b1, 1'b1, 6'd32, 4, 1'b1);

        // R9: stray data-last without enable during data phase
        req_addr = 32'hA5A5_5A5A; req_burst = 1'b0; req_dual = 1'b0;
        req_bar_bits = 6'd8; req_valid = 1'b1;
        tick; req_valid = 1'b0;
        tick;
        rd_en_n = 1'b1; rd_data_last_n = 1'b0;
        tick;
        rd_data_last_n = 1'b1;
        check("R9 error pulse", 32'(proto_err), 32'd1);
        check("R9 phase not ended", 32'(ready), 32'd0);
        tick;
        check("R9 error one cycle", 32'(proto_err), 32'd0);
        // R10: data-last on a low piece
        rd_en_n = 1'b0; rd_piece = 16'h4242; rd_data_last_n = 1'b0;
        tick;
        rd_en_n = 1'b1; rd_data_last_n = 1'b1;
        check("R10 error on low last", 32'(proto_err), 32'd1);
        check("R10 no word", 32'(rd_word_valid), 32'd0);
        check("R10 phase ended", 32'(ready), 32'd1);
        tick;
        check("R10 error one cycle", 32'(proto_err), 32'd0);

        for (int i = 0; i < 200; i++) begin
            logic [5:0] bits;
            bits = 6'($urandom_range(4, 32));
            run_txn($urandom, 1'($urandom), 1'($urandom), bits,
                    int'($urandom_range(1, 4)), bit'($urandom));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule